// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a 16-bit voltage-output converter. A host drives three wires into it: an active-low frame select, a serial clock and a serial data line. The block assembles each frame into a 24-bit command. A frame that completes loads a 16-bit code register and a 2-bit output-stage mode register. The held code, the mode and a one-hot decode of the mode go to the analog output stage.

All three serial wires are asynchronous to the block. They are brought into a faster system clock through a synchronizer, and every edge is found by comparing successive synchronized samples. The system clock must run at least four times the serial clock rate. A frame that the host abandons early has no effect. Once a frame has completed, the host must raise and lower the frame select again before the next command is accepted.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, code_o is 0, stage_mode_o is 00 (drive), stage_sel_o is 0001 and update_o is low.
- R2: A command starts only when frame_n_i goes from high to low. Serial clock edges while frame_n_i is high change neither the code nor the mode.
- R3: Data bits are taken on falling edges of sclk_i, most significant bit first. In the 24-bit command, bits 15:0 are the code, bits 17:16 are the mode, and bits 23:18 are ignored.
- R4: On the 24th falling sclk_i edge of a command, the code and the mode are loaded together. update_o is high for exactly one system clock cycle per completed command, in the same cycle that the new values first appear.
- R5: If frame_n_i rises before the 24th falling edge, the partial command is discarded. The code and the mode keep their values and update_o stays low.
- R6: After the 24th edge, further sclk_i edges while frame_n_i stays low are ignored. A new command needs frame_n_i to go high and then low again.
- R7: Mode encoding: 00 drive, 01 output to ground through 1 kohm, 10 output to ground through 100 kohm, 11 high impedance. stage_sel_o is one-hot with bit index equal to the mode value.
- R8: While a power-down mode (01, 10 or 11) is active, code_o keeps presenting the stored code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| code_o | output | 16 | Held converter code |
| stage_mode_o | output | 2 | Held output-stage mode |
| stage_sel_o | output | 4 | One-hot decode of the mode |
| update_o | output | 1 | One-cycle strobe on each completed command |

## Verification
A wrong bit counter or a stale shift register would show up as a wrong code or mode in the cycle that update_o pulses, or as a missing or extra pulse. The scoreboard pairs each pulse with the command that caused it. A state machine that fails to drop a partial frame, or that re-arms without a new falling edge of frame select, would produce a spurious update. That update appears within a few system clocks of the stray serial edges and is reported as an unexpected pulse. A decode fault shows at once on stage_sel_o, because stage_sel_o is compared with the mode in the same cycle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        STAGE_DRIVE    = 2'b00,
        STAGE_GND_1K   = 2'b01,
        STAGE_GND_100K = 2'b10,
        STAGE_OPEN     = 2'b11
    } stage_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_SHIFT = 2'b01,
        RX_DONE  = 2'b10
    } rx_state_e;

endpackage

// File: rtl/sdac_in_sync.sv
module sdac_in_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= RST_LVL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign lvl_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift
    import sdac_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int KEEP_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_lvl_i,
    input  logic              sclk_lvl_i,
    input  logic              data_lvl_i,
    output logic              commit_o,
    output logic [KEEP_W-1:0] word_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              commit;
        logic              frame_prev;
        logic              sclk_prev;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic frame_fall, frame_rise, sclk_fall;

    always_comb begin
        frame_fall = r_q.frame_prev & ~frame_lvl_i;
        frame_rise = ~r_q.frame_prev & frame_lvl_i;
        sclk_fall  = r_q.sclk_prev & ~sclk_lvl_i;

        r_d            = r_q;
        r_d.commit     = 1'b0;
        r_d.frame_prev = frame_lvl_i;
        r_d.sclk_prev  = sclk_lvl_i;

        if (frame_rise) begin
            r_d.state = RX_IDLE;
            r_d.cnt   = '0;
            r_d.shreg = '0;
        end else if (frame_fall) begin
            r_d.state = RX_SHIFT;
            r_d.cnt   = '0;
            r_d.shreg = '0;
        end else if (r_q.state == RX_SHIFT && sclk_fall) begin
            r_d.shreg = (r_q.shreg << 1) | WORD_W'(data_lvl_i);
            if (r_q.cnt == LAST_BIT) begin
                r_d.state  = RX_DONE;
                r_d.cnt    = '0;
                r_d.commit = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.state      <= RX_IDLE;
            r_q.frame_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign commit_o = r_q.commit;
    assign word_o   = r_q.shreg[KEEP_W-1:0];

    // R2: the shift state is only ever entered after frame select was seen low
    a_r2_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == RX_SHIFT) |-> $past(!frame_lvl_i));

    // R3: the bit counter never passes the word length
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_SHIFT) |-> (r_q.cnt <= LAST_BIT));

    // R5: frame select rising mid-frame returns to idle with no commit
    a_r5_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_SHIFT && frame_lvl_i) |=> (r_q.state == RX_IDLE && !r_q.commit));

    // R6: a commit always leaves the receiver parked until a new frame
    a_r6_commit_parks: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.commit |-> (r_q.state == RX_DONE));

endmodule

// File: rtl/sdac_cmd_hold.sv
module sdac_cmd_hold #(
    parameter int CODE_W = 16,
    parameter int MODE_W = 2,
    parameter int NSEL   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_i,
    input  logic [CODE_W+MODE_W-1:0] word_i,
    output logic [CODE_W-1:0]        code_o,
    output logic [MODE_W-1:0]        mode_o,
    output logic [NSEL-1:0]          sel_o,
    output logic                     update_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [MODE_W-1:0] mode;
        logic              upd;
    } hold_regs_t;

    hold_regs_t h_d, h_q;

    always_comb begin
        h_d     = h_q;
        h_d.upd = commit_i;
        if (commit_i) begin
            h_d.code = word_i[CODE_W-1:0];
            h_d.mode = word_i[CODE_W +: MODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    always_comb begin
        sel_o = '0;
        sel_o[h_q.mode] = 1'b1;
    end

    assign code_o   = h_q.code;
    assign mode_o   = h_q.mode;
    assign update_o = h_q.upd;

    // R4: the update strobe is a single-cycle pulse
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R5: code and mode only move in a strobe cycle
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> ($stable(code_o) && $stable(mode_o)));

    // R7: the stage select is always exactly one-hot
    a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o) == 1);

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
    parameter int CODE_W      = 16,
    parameter int MODE_W      = 2,
    parameter int PAD_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_n_i,
    input  logic                  sclk_i,
    input  logic                  sdata_i,
    output logic [CODE_W-1:0]     code_o,
    output logic [MODE_W-1:0]     stage_mode_o,
    output logic [(1<<MODE_W)-1:0] stage_sel_o,
    output logic                  update_o
);

    localparam int WORD_W = PAD_W + MODE_W + CODE_W;
    localparam int KEEP_W = MODE_W + CODE_W;
    localparam int NSEL   = 1 << MODE_W;

    logic [2:0]        lvl;
    logic              commit;
    logic [KEEP_W-1:0] word;

    sdac_in_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_LVL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, sclk_i, frame_n_i}),
        .lvl_o   (lvl)
    );

    sdac_frame_shift #(
        .WORD_W (WORD_W),
        .KEEP_W (KEEP_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_lvl_i (lvl[0]),
        .sclk_lvl_i  (lvl[1]),
        .data_lvl_i  (lvl[2]),
        .commit_o    (commit),
        .word_o      (word)
    );

    sdac_cmd_hold #(
        .CODE_W (CODE_W),
        .MODE_W (MODE_W),
        .NSEL   (NSEL)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .code_o   (code_o),
        .mode_o   (stage_mode_o),
        .sel_o    (stage_sel_o),
        .update_o (update_o)
    );

endmodule

// File: tb/test_sdac_frame_rx.sv
module test_sdac_frame_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic [15:0] code_o;
    logic [1:0]  stage_mode_o;
    logic [3:0]  stage_sel_o;
    logic        update_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [17:0] expq[$];
    logic [15:0] cur_code = 16'h0000;
    logic [1:0]  cur_mode = 2'b00;

    always #2 clk = ~clk;

    sdac_frame_rx i_sdac_frame_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n_i    (frame_n),
        .sclk_i       (sclk),
        .sdata_i      (sdata),
        .code_o       (code_o),
        .stage_mode_o (stage_mode_o),
        .stage_sel_o  (stage_sel_o),
        .update_o     (update_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sys(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_sclk(input logic bitval);
        @(negedge clk); sclk = 1'b1; sdata = bitval;
        sys(4);
        @(negedge clk); sclk = 1'b0;
        sys(4);
    endtask

    // driver: sends nbits of w; only complete frames are pushed to the scoreboard
    task automatic send(input logic [23:0] w, input int nbits, input bit stay_low);
        if (nbits == 24) begin
            expq.push_back(w[17:0]);
            cur_code = w[15:0];
            cur_mode = w[17:16];
        end
        @(negedge clk); frame_n = 1'b0;
        sys(4);
        for (int i = 23; i > 23 - nbits; i--) pulse_sclk(w[i]);
        if (!stay_low) begin
            @(negedge clk); frame_n = 1'b1;
            sys(4);
        end
        sys(8);
    endtask

    task automatic check_held(input string req);
        @(negedge clk);
        check(code_o == cur_code, req, 32'(code_o), 32'(cur_code));
        check(stage_mode_o == cur_mode, req, 32'(stage_mode_o), 32'(cur_mode));
    endtask

    // monitor: pop one expected command per strobe
    always @(negedge clk) begin
        if (rst_n && update_o && !finished) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4 unexpected update", 32'(code_o), 32'h0);
            end else begin
                logic [17:0] e;
                e = expq.pop_front();
                check(code_o == e[15:0], "R3 code", 32'(code_o), 32'(e[15:0]));
                check(stage_mode_o == e[17:16], "R3 mode", 32'(stage_mode_o), 32'(e[17:16]));
                check(stage_sel_o == (4'b0001 << e[17:16]), "R7 select", 32'(stage_sel_o),
                      32'(4'b0001 << e[17:16]));
            end
        end
    end

    initial begin
        sys(200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        sys(5);
        @(negedge clk);
        check(code_o == 16'h0 && stage_mode_o == 2'b00, "R1 reset code/mode",
              32'({code_o, stage_mode_o}), 32'h0);
        check(stage_sel_o == 4'b0001, "R1 reset select", 32'(stage_sel_o), 32'h1);
        rst_n = 1'b1;
        sys(6);
        @(negedge clk);
        check(code_o == 16'h0, "R1 code after reset", 32'(code_o), 32'h0);
        check(update_o == 1'b0, "R1 no strobe", 32'(update_o), 32'h0);

        // R2: clock activity with frame select high
        for (int k = 0; k < 30; k++) pulse_sclk(k[0]);
        check_held("R2 idle clocks");

        // R3/R7: pad bits set, then each mode
        send(24'hFC_1234, 24, 0);
        check_held("R3 pad ignored");
        send(24'h01_ABCD, 24, 0);
        check(stage_sel_o == 4'b0010, "R7 1k select", 32'(stage_sel_o), 32'h2);
        check_held("R8 code in 1k mode");
        send(24'h3E_5A5A, 24, 0);
        check(stage_sel_o == 4'b0100, "R7 100k select", 32'(stage_sel_o), 32'h4);
        send(24'h03_FFFF, 24, 0);
        check(stage_sel_o == 4'b1000, "R7 open select", 32'(stage_sel_o), 32'h8);
        check_held("R8 code in open mode");
        send(24'h00_0001, 24, 0);
        check_held("R7 back to drive");

        // R5: aborts at 23 and at 1 bit
        send(24'h02_7777, 23, 0);
        check_held("R5 abort at 23");
        send(24'h03_0F0F, 1, 0);
        check_held("R5 abort at 1");

        // R6: stay low after completion, keep clocking
        send(24'h01_8000, 24, 1);
        for (int k = 0; k < 24; k++) pulse_sclk(1'b1);
        sys(8);
        check_held("R6 extra edges ignored");
        @(negedge clk); frame_n = 1'b1;
        sys(4);
        send(24'h00_4321, 24, 0);
        check_held("R6 new frame after high");

        sys(10);
        check(expq.size() == 0, "R4 all strobes seen", 32'(expq.size()), 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule